// File: doc/BRIEF.md
# Slot Command Ring Queue

This block is a circular queue of fixed 64-byte command slots held in an on-chip array of 64-bit words. A producer asks for a slot with a one-cycle request. If the queue has room, the block opens a fill window and takes exactly eight 64-bit beats. After the eighth beat the slot is committed and the write pointer moves on by one slot.

A consumer works through two separate operations. A peek streams the head slot out as eight beats with a valid/ready handshake, and it can be repeated without losing anything. A pop discards the head slot by advancing the read pointer. Both pointers count in bytes, step by 64 and wrap at a loadable capacity. A load operation sets the capacity and both pointers to arbitrary slot-aligned values, so the ring can resume from any position.

One slot of the ring always stays unused. This lets equal pointers mean empty and nothing else: the queue reports full once the occupancy reaches the capacity minus 64 bytes.

Top module: `cmd_ring_queue`

## Requirements
- R1: After reset, empty is 1, full is 0, wr_ready and rd_valid are 0, the capacity is CAP_SLOTS*64 bytes and both pointers are 0.
- R2: A push_req that is accepted raises wr_ready on the next cycle. The block takes one beat on every cycle in which wr_valid and wr_ready are both high, and idle cycles between beats are allowed. On the edge that takes the eighth beat, wr_ready falls, push_done pulses high for exactly one cycle and the write pointer advances by 64 bytes.
- R3: A push_req while full, or while a fill is already under way, gives a one-cycle push_rej and opens no fill window. The contents and the status stay unchanged.
- R4: An accepted peek_req streams the head slot as eight beats in the order they were written, with rd_last high on the eighth beat only. rd_valid holds while rd_ready is low. A peek does not move the read pointer, so a second peek returns the same slot.
- R5: A peek_req while the queue is empty, or while a peek is already streaming, gives a one-cycle peek_rej and produces no beats.
- R6: An accepted pop_req advances the read pointer by 64 bytes. A pop_req while empty gives a one-cycle pop_rej and leaves the queue unchanged.
- R7: empty and full are registered outputs. They reflect the pointers in the cycle after any update. empty is 1 exactly when the two pointers are equal. full is 1 exactly when the occupancy equals the capacity minus 64. The occupancy is wptr-rptr when wptr is at least rptr, and capacity-(rptr-wptr) otherwise.
- R8: init_en loads the capacity and both pointers from init_cap, init_rptr and init_wptr, with the low 6 bits of each forced to 0. It aborts any fill or peek in progress, and a partly written slot is never committed.
- R9: Both pointers wrap to 0 when a 64-byte step reaches the capacity, and slots are read back in FIFO order across the wrap.
- R10: A push whose eighth beat lands in the same cycle as an accepted pop applies both pointer updates. The occupancy then stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_en | input | 1 | Load capacity and pointers |
| init_cap | input | PW | Capacity in bytes to load |
| init_rptr | input | PW | Read pointer in bytes to load |
| init_wptr | input | PW | Write pointer in bytes to load |
| push_req | input | 1 | Request to write one slot |
| wr_valid | input | 1 | Write beat valid |
| wr_data | input | BEAT_W | Write beat data |
| wr_ready | output | 1 | Fill window open |
| push_done | output | 1 | Slot committed (one-cycle pulse) |
| push_rej | output | 1 | Push refused (one-cycle pulse) |
| peek_req | input | 1 | Request to stream the head slot |
| rd_ready | input | 1 | Consumer accepts the read beat |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | BEAT_W | Read beat data |
| rd_last | output | 1 | Eighth beat of the slot |
| peek_rej | output | 1 | Peek refused (one-cycle pulse) |
| pop_req | input | 1 | Request to discard the head slot |
| pop_rej | output | 1 | Pop refused (one-cycle pulse) |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full (one slot kept free) |

## Verification
The ring is loaded to a four-slot capacity with both pointers near the top of the buffer. Filling it to full therefore forces the write pointer through the wrap, and later peeks show whether FIFO order holds across the boundary. Fills with a gap between beats and peeks under back-pressure separate true handshaking from fixed-cycle sequencing. Pushes and pops are also tried in several other patterns: refused on a full or empty ring, a pop landing on the final write beat, and a load arriving in the middle of a fill. Each of these shows whether the pointers move only on an accepted request, and whether an aborted slot stays out of the queue.

// File: rtl/cmd_ring_queue.sv
module cmd_ring_queue #(
  parameter int CAP_SLOTS = 128,
  parameter int BEAT_W    = 64,
  localparam int MAX_B    = CAP_SLOTS * 64,
  localparam int PW       = $clog2(MAX_B) + 1,
  localparam int SW       = $clog2(CAP_SLOTS),
  localparam int AW       = SW + 3,
  localparam int WORDS    = CAP_SLOTS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic [PW-1:0]     init_cap,
  input  logic [PW-1:0]     init_rptr,
  input  logic [PW-1:0]     init_wptr,
  input  logic              push_req,
  input  logic              wr_valid,
  input  logic [BEAT_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              push_done,
  output logic              push_rej,
  input  logic              peek_req,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_data,
  output logic              rd_last,
  output logic              peek_rej,
  input  logic              pop_req,
  output logic              pop_rej,
  output logic              empty,
  output logic              full
);

  logic [BEAT_W-1:0] mem [WORDS];
  logic [PW-1:0] cap_q, rp_q, wp_q, cap_n, rp_n, wp_n;
  logic          fill_q, pk_q;
  logic [2:0]    wbeat_q, pbeat_q;
  logic [SW-1:0] pbase_q;
  logic          empty_q, full_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [PW-1:0] c);
    logic [PW:0] s;
    s = {1'b0, p} + (PW+1)'(64);
    if (s >= {1'b0, c}) s = s - {1'b0, c};
    return s[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] occ(input logic [PW-1:0] w, input logic [PW-1:0] r,
                                        input logic [PW-1:0] c);
    return (w >= r) ? (w - r) : (c - (r - w));
  endfunction

  function automatic logic [PW-1:0] align(input logic [PW-1:0] v);
    return {v[PW-1:6], 6'b0};
  endfunction

  wire wr_fire = fill_q & wr_valid;
  wire last_w  = wr_fire & (wbeat_q == 3'd7);
  wire push_ok = push_req & ~init_en & ~fill_q & ~full_q;
  wire pop_ok  = pop_req & ~init_en & ~empty_q;
  wire peek_ok = peek_req & ~init_en & ~pk_q & ~empty_q;
  wire rd_fire = pk_q & rd_ready;

  always_comb begin
    cap_n = cap_q;
    rp_n  = rp_q;
    wp_n  = wp_q;
    if (init_en) begin
      cap_n = align(init_cap);
      rp_n  = align(init_rptr);
      wp_n  = align(init_wptr);
    end else begin
      if (last_w) wp_n = step(wp_q, cap_q);
      if (pop_ok) rp_n = step(rp_q, cap_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= PW'(MAX_B);
      rp_q    <= '0;
      wp_q    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      cap_q   <= cap_n;
      rp_q    <= rp_n;
      wp_q    <= wp_n;
      empty_q <= (rp_n == wp_n);
      full_q  <= (occ(wp_n, rp_n, cap_n) == cap_n - PW'(64));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= 1'b0;
      wbeat_q   <= '0;
      push_done <= 1'b0;
      push_rej  <= 1'b0;
    end else begin
      push_done <= last_w & ~init_en;
      push_rej  <= push_req & ~init_en & (fill_q | full_q);
      if (init_en) begin
        fill_q  <= 1'b0;
        wbeat_q <= '0;
      end else if (push_ok) begin
        fill_q  <= 1'b1;
        wbeat_q <= '0;
      end else if (wr_fire) begin
        wbeat_q <= wbeat_q + 3'd1;
        if (last_w) fill_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire && !init_en) mem[AW'({wp_q[6 +: SW], wbeat_q})] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_q     <= 1'b0;
      pbeat_q  <= '0;
      pbase_q  <= '0;
      peek_rej <= 1'b0;
      pop_rej  <= 1'b0;
    end else begin
      peek_rej <= peek_req & ~init_en & (pk_q | empty_q);
      pop_rej  <= pop_req & ~init_en & empty_q;
      if (init_en) begin
        pk_q    <= 1'b0;
        pbeat_q <= '0;
      end else if (peek_ok) begin
        pk_q    <= 1'b1;
        pbeat_q <= '0;
        pbase_q <= rp_q[6 +: SW];
      end else if (rd_fire) begin
        pbeat_q <= pbeat_q + 3'd1;
        if (pbeat_q == 3'd7) pk_q <= 1'b0;
      end
    end
  end

  assign wr_ready = fill_q;
  assign rd_valid = pk_q;
  assign rd_last  = pk_q & (pbeat_q == 3'd7);
  assign rd_data  = mem[AW'({pbase_q, pbeat_q})];
  assign empty    = empty_q;
  assign full     = full_q;

endmodule

module cmd_ring_queue_chk (
  input logic clk,
  input logic rst_n,
  input logic init_en,
  input logic push_req,
  input logic pop_req,
  input logic peek_req,
  input logic rd_ready,
  input logic rd_valid,
  input logic rd_last,
  input logic wr_ready,
  input logic push_done,
  input logic push_rej,
  input logic pop_rej,
  input logic peek_rej,
  input logic empty,
  input logic full
);
  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !init_en |=> pop_rej);
  // R3
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && full && !init_en |=> push_rej && !wr_ready);
  // R5
  peek_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peek_req && empty && !init_en |=> peek_rej && !rd_valid);
  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !init_en |=> rd_valid);
  // R2
  done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |-> !wr_ready && !push_rej);
  // R7
  done_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |-> !empty);
endmodule

bind cmd_ring_queue cmd_ring_queue_chk u_chk (.*);

// File: tb/sim_cmd_ring_queue.sv
module sim_cmd_ring_queue;
  localparam int PW = 14;

  logic clk = 0, rst_n = 0;
  logic init_en = 0;
  logic [PW-1:0] init_cap = '0, init_rptr = '0, init_wptr = '0;
  logic push_req = 0, wr_valid = 0;
  logic [63:0] wr_data = '0;
  logic wr_ready, push_done, push_rej;
  logic peek_req = 0, rd_ready = 1;
  logic rd_valid, rd_last, peek_rej;
  logic [63:0] rd_data;
  logic pop_req = 0;
  logic pop_rej, empty, full;

  int total = 0, bad = 0;
  int mq[$];
  logic [63:0] exp_d[$];
  bit exp_l[$];

  always #5 clk = ~clk;

  cmd_ring_queue u0 (.*);

  function automatic logic [63:0] word(input int tag, input int j);
    return {32'hA5000000 | 32'(tag), 32'(j)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_d.size() == 0) chk(0, "R4 unexpected beat", rd_data, 0);
      else begin
        logic [63:0] d;
        bit l;
        d = exp_d.pop_front();
        l = exp_l.pop_front();
        chk(rd_data == d, "R4 beat data", rd_data, d);
        chk(rd_last == l, "R4 last flag", 64'(rd_last), 64'(l));
      end
    end
  end

  task automatic do_init(input int cap, input int rp, input int wp);
    @(posedge clk); #1;
    init_en = 1; init_cap = PW'(cap); init_rptr = PW'(rp); init_wptr = PW'(wp);
    @(posedge clk); #1;
    init_en = 0;
    mq.delete();
  endtask

  task automatic do_push(input int tag, input bit gap, input bit pop_last, input bit exp_rej);
    @(posedge clk); #1 push_req = 1;
    @(posedge clk); #1 push_req = 0;
    chk(push_rej == exp_rej, "R3 push_rej", 64'(push_rej), 64'(exp_rej));
    if (exp_rej) begin
      chk(wr_ready == 0, "R3 no fill window", 64'(wr_ready), 0);
      @(posedge clk); #1;
      chk(push_rej == 0, "R3 rej pulse", 64'(push_rej), 0);
      return;
    end
    chk(wr_ready == 1, "R2 fill window", 64'(wr_ready), 1);
    for (int j = 0; j < 8; j++) begin
      if (gap && j == 3) begin wr_valid = 0; @(posedge clk); #1; end
      wr_valid = 1; wr_data = word(tag, j);
      if (pop_last && j == 7) pop_req = 1;
      @(posedge clk); #1;
    end
    wr_valid = 0; pop_req = 0;
    chk(push_done == 1, "R2 push_done", 64'(push_done), 1);
    chk(wr_ready == 0, "R2 window closed", 64'(wr_ready), 0);
    if (pop_last) void'(mq.pop_front());
    mq.push_back(tag);
    @(posedge clk); #1;
    chk(push_done == 0, "R2 done pulse", 64'(push_done), 0);
  endtask

  task automatic do_pop(input bit exp_rej);
    @(posedge clk); #1 pop_req = 1;
    @(posedge clk); #1 pop_req = 0;
    chk(pop_rej == exp_rej, "R6 pop_rej", 64'(pop_rej), 64'(exp_rej));
    if (!exp_rej) void'(mq.pop_front());
  endtask

  task automatic do_peek(input bit exp_rej, input bit stall);
    int cyc = 0;
    if (!exp_rej)
      for (int j = 0; j < 8; j++) begin
        exp_d.push_back(word(mq[0], j));
        exp_l.push_back(j == 7);
      end
    @(posedge clk); #1 peek_req = 1;
    @(posedge clk); #1 peek_req = 0;
    chk(peek_rej == exp_rej, "R5 peek_rej", 64'(peek_rej), 64'(exp_rej));
    if (exp_rej) begin
      chk(rd_valid == 0, "R5 no beats", 64'(rd_valid), 0);
      return;
    end
    while (exp_d.size() != 0) begin
      rd_ready = stall ? cyc[0] : 1'b1;
      cyc++;
      @(posedge clk); #1;
    end
    rd_ready = 1;
    chk(rd_valid == 0, "R4 stream ends", 64'(rd_valid), 0);
  endtask

  task automatic chk_status(input bit e, input bit f, input string req);
    chk(empty == e, {req, " empty"}, 64'(empty), 64'(e));
    chk(full == f, {req, " full"}, 64'(full), 64'(f));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk_status(1, 0, "R1");
    chk(wr_ready == 0 && rd_valid == 0, "R1 idle", {wr_ready, rd_valid}, 0);
    // R5, R6 refusals on empty
    do_peek(1, 0);
    do_pop(1);
    chk_status(1, 0, "R6 after refused pop");
    // R2 push with a gap, R7 status
    do_push(11, 1, 0, 0);
    chk_status(0, 0, "R7 one slot");
    // R4 peek twice, second under back-pressure
    do_peek(0, 0);
    do_peek(0, 1);
    do_pop(0);
    chk_status(1, 0, "R6 R7 after pop");
    // R8 load with unaligned pointers near the top
    do_init(256, 197, 197);
    chk_status(1, 0, "R8 after init");
    // R9 wrap while filling
    do_push(1, 0, 0, 0);
    do_push(2, 0, 0, 0);
    do_push(3, 1, 0, 0);
    chk_status(0, 1, "R7 full at cap-64");
    // R3 refused push while full
    do_push(9, 0, 0, 1);
    chk_status(0, 1, "R3 still full");
    do_peek(0, 0);
    do_pop(0);
    chk_status(0, 0, "R6 pop from full");
    // R9 head after read wrap
    do_peek(0, 1);
    // R10 push completes with a pop
    do_push(4, 0, 1, 0);
    chk_status(0, 0, "R10 occupancy kept");
    do_peek(0, 0);
    do_pop(0);
    do_peek(0, 0);
    do_pop(0);
    chk_status(1, 0, "R9 drained");
    do_pop(1);
    // R8 init aborts a fill
    @(posedge clk); #1 push_req = 1;
    @(posedge clk); #1 push_req = 0;
    for (int j = 0; j < 3; j++) begin
      wr_valid = 1; wr_data = word(99, j);
      @(posedge clk); #1;
    end
    wr_valid = 0;
    do_init(256, 64, 64);
    chk(wr_ready == 0, "R8 fill aborted", 64'(wr_ready), 0);
    chk(push_done == 0, "R8 no commit", 64'(push_done), 0);
    chk_status(1, 0, "R8 empty after abort");
    do_push(7, 0, 0, 0);
    do_peek(0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule